// File: doc/BRIEF.md
# Four-Word Burst Offset Sequencer

This block produces the low word-offset bits of a short memory burst. When a new access begins, the caller pulses the load strobe together with the low bits of the starting address. Those bits become the first offset on the output. Each later clock edge with the active-low step input low moves the output to the next word of the burst. The upper address bits never pass through this block; the address register passes them on unchanged.

Two visiting orders are available, chosen by a mode input that stays fixed during operation. In interleaved order, word n of the burst sits at the start offset XOR n. In linear order, word n sits at the start offset plus n, modulo the burst length. With the step input held high, the burst pauses and keeps its place. After the last word the sequence wraps back to the start offset, so a burst gives four words: the loaded one and three steps.

Top module: `burst_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the captured start and the step count, so the offset output reads 00 in the cycle after reset.
- R2: When `load` is high at a clock edge, the offset output equals the `start_lo` value sampled at that edge from the next cycle onward.
- R3: When `load` is low and `step_n` is low at a clock edge, the burst moves forward by one word.
- R4: When `load` is low and `step_n` is high at a clock edge, the offset output keeps its value, and a later step continues from the word where the burst paused.
- R5: With `order_ilv` = 1 (interleaved), word n of the burst is the start offset XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R6: With `order_ilv` = 0 (linear), word n is the start offset plus n, modulo 4. For example, a start of 01 gives 01, 10, 11, 00.
- R7: The step that follows the fourth word brings the offset back to the start offset, in both orders.
- R8: When `load` and a step (`step_n` low) occur at the same edge, the load wins: the output becomes the new start and the step count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Starts a new burst and captures `start_lo` |
| start_lo | input | 2 | Low address bits of the first word |
| step_n | input | 1 | Active-low step; high pauses the burst |
| order_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order (static) |
| offset | output | 2 | Word offset of the current burst beat |

## Verification
The bench runs every start value in both orders through a full burst and one more step. This catches a design that swaps the two orders, one that treats interleaved order as an add with carry (start 01 would then go to 10 instead of 00), and one that fails to wrap back to the start. A pause in the middle of a burst checks that the count is not lost: if it were, the burst would restart or skip a word. A load given together with a step checks the priority: a wrong design would output start+1 or keep part of the old count. A reset given in the middle of a burst must bring the output back to 00.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Offset of beat `n` of a burst that began at `base`.
  // Interleaved order flips bits of the base; linear order adds with wrap.
  function automatic logic [1:0] beat_offset2(input logic [1:0] base,
                                              input logic [1:0] n,
                                              input logic       ilv);
    beat_offset2 = ilv ? (base ^ n) : (base + n);
  endfunction
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_evt,
  input  logic [OFF_W-1:0] start_lo,
  output logic [OFF_W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (rst)           start_q <= '0;
    else if (load_evt) start_q <= start_lo;
  end
endmodule

// File: rtl/burst_step_count.sv
module burst_step_count #(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_evt,
  input  logic             step_evt,
  output logic [OFF_W-1:0] count_q
);
  // Load beats a step; the count wraps on its own after the last beat.
  always_ff @(posedge clk) begin
    if (rst)           count_q <= '0;
    else if (load_evt) count_q <= '0;
    else if (step_evt) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map #(
  parameter int OFF_W = 2
) (
  input  logic [OFF_W-1:0] start_q,
  input  logic [OFF_W-1:0] count_q,
  input  logic             order_ilv,
  output logic [OFF_W-1:0] offset
);
  generate
    if (OFF_W == 2) begin : g_pkg_fn
      always_comb offset = burst_seq_pkg::beat_offset2(start_q, count_q, order_ilv);
    end else begin : g_generic
      always_comb offset = order_ilv ? (start_q ^ count_q) : (start_q + count_q);
    end
  endgenerate
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] start_lo,
  input  logic             step_n,
  input  logic             order_ilv,
  output logic [OFF_W-1:0] offset
);
  // Named events, visible to the bound checker.
  logic             load_evt;
  logic             step_evt;
  logic [OFF_W-1:0] start_q;
  logic [OFF_W-1:0] count_q;

  assign load_evt = load;
  assign step_evt = ~step_n & ~load;

  burst_start_reg #(.OFF_W(OFF_W)) u_start (
    .clk(clk), .rst(rst), .load_evt(load_evt), .start_lo(start_lo), .start_q(start_q)
  );

  burst_step_count #(.OFF_W(OFF_W)) u_count (
    .clk(clk), .rst(rst), .load_evt(load_evt), .step_evt(step_evt), .count_q(count_q)
  );

  burst_offset_map #(.OFF_W(OFF_W)) u_map (
    .start_q(start_q), .count_q(count_q), .order_ilv(order_ilv), .offset(offset)
  );
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int OFF_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [OFF_W-1:0] start_lo,
  input logic             step_n,
  input logic             order_ilv,
  input logic [OFF_W-1:0] offset,
  input logic [OFF_W-1:0] count_q
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (offset == '0));

  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (offset == $past(start_lo)));

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && !step_n) |=> (count_q == OFF_W'($past(count_q) + 1'b1)));

  assert_pause_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && step_n) |=> $stable(offset));

  assert_linear_step_R6: assert property (@(posedge clk) disable iff (rst)
    (!order_ilv && !load && !step_n) |=> (offset == OFF_W'($past(offset) + 1'b1)));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (load && !step_n) |=> (count_q == '0));
endmodule

bind burst_seq burst_seq_chk #(.OFF_W(OFF_W)) chk_i (
  .clk(clk), .rst(rst), .load(load), .start_lo(start_lo), .step_n(step_n),
  .order_ilv(order_ilv), .offset(offset), .count_q(count_q)
);

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // Entry: {order_ilv, start, beat0, beat1, beat2, beat3}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2},
    {1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0},
    {1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3},
    {1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0},
    {1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1},
    {1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [1:0] start_lo = 2'd0;
  logic       step_n = 1'b1;
  logic       order_ilv = 1'b0;
  logic [1:0] offset;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq dut_i (
    .clk(clk), .rst(rst), .load(load), .start_lo(start_lo),
    .step_n(step_n), .order_ilv(order_ilv), .offset(offset)
  );

  task automatic chk(input logic [1:0] exp, input string req);
    n_chk++;
    if (offset !== exp) begin
      n_bad++;
      $display("FAIL %s: offset=%0d expected=%0d at %0t", req, offset, exp, $time);
    end
  endtask

  // Drive at the falling edge; the next falling edge sees the result.
  task automatic cyc(input logic ld, input logic [1:0] st, input logic sn);
    load = ld; start_lo = st; step_n = sn;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(2'd0, "R1 reset state");

    // Table walk: full burst plus one wrap step, both orders (R5 R6 R7 R2 R3)
    for (int v = 0; v < NVEC; v++) begin
      order_ilv = VEC[v][10];
      cyc(1'b1, VEC[v][9:8], 1'b1);
      chk(VEC[v][7:6], "R2 load start");
      for (int b = 1; b < 4; b++) begin
        cyc(1'b0, 2'd0, 1'b0);
        chk(VEC[v][7 - 2*b -: 2], VEC[v][10] ? "R5 interleaved beat R3" : "R6 linear beat R3");
      end
      cyc(1'b0, 2'd0, 1'b0);
      chk(VEC[v][7:6], "R7 wrap to start");
    end

    // Pause mid-burst, interleaved start 10: 10, 11, (hold), 00, 01
    order_ilv = 1'b1;
    cyc(1'b1, 2'd2, 1'b1);
    cyc(1'b0, 2'd0, 1'b0);
    chk(2'd3, "R4 before pause");
    cyc(1'b0, 2'd0, 1'b1);
    chk(2'd3, "R4 hold 1");
    cyc(1'b0, 2'd1, 1'b1);
    chk(2'd3, "R4 hold 2 start_lo ignored");
    cyc(1'b0, 2'd0, 1'b0);
    chk(2'd0, "R4 resume");
    cyc(1'b0, 2'd0, 1'b0);
    chk(2'd1, "R4 resume 2");

    // Load together with a step, linear order
    order_ilv = 1'b0;
    cyc(1'b1, 2'd1, 1'b0);
    cyc(1'b0, 2'd0, 1'b0);          // count now 1
    cyc(1'b1, 2'd3, 1'b0);          // load wins
    chk(2'd3, "R8 load beats step");
    cyc(1'b0, 2'd0, 1'b0);
    chk(2'd0, "R8 count restarted");

    // Reset in the middle of a burst
    cyc(1'b0, 2'd0, 1'b0);
    rst = 1'b1;
    cyc(1'b0, 2'd0, 1'b0);
    rst = 1'b0;
    chk(2'd0, "R1 mid-burst reset");
    cyc(1'b0, 2'd0, 1'b0);
    chk(2'd1, "R1 step after reset");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule